// File: doc/BRIEF.md
# Memory Map Decoder with Wait-State Sequencer

This block sits between a processor's address generation and its memories. For every access it looks at the address, whether the access targets program space or data space, and an overlay control bit. From these it picks one of four regions: memory-mapped registers, a 32-word scratch RAM, internal dual-access RAM, or external memory. The region select is a combinational function of the request. Internal regions answer in the same cycle. External accesses are stretched by a per-space wait count, with one count for data SRAM and another for program flash.

External memory may not be accessed in back-to-back bus cycles. After an external access completes, the next cycle is a recovery cycle. An external request that shows up in that cycle is held off for one cycle before it is started. Internal requests are never held off. A requester raises `req_i` and holds the address and space select steady until it sees `ready_o` high. The access completes in the cycle where `ready_o` is high.

Data space uses the low 16 bits of the address. Program addresses are 20 bits: a 4-bit page in the top bits and a 16-bit offset.

Top module: `memmap_waitgen`

## Requirements
- R1: A data request (`prog_i`=0) with offset 0x0000 to 0x005F drives `sel_mmr_o` high. Address bits 19:16 are ignored for data requests.
- R2: A data request with offset 0x0060 to 0x007F drives `sel_scr_o` high.
- R3: A data request with offset 0x0080 to 0x3FFF drives `sel_int_o` high and never `sel_ext_o`.
- R4: A data request with offset 0x4000 to 0xFFFF drives `sel_ext_o` high and takes DATA_WS wait states (default 1).
- R5: With `ovly_i`=0, every program request (`prog_i`=1), on any page and at any offset, drives `sel_ext_o` and takes PROG_WS wait states (default 7).
- R6: With `ovly_i`=1, a program request whose 16-bit offset is below 0x4000 drives `sel_int_o` on every page. Program offsets of 0x4000 and above stay external. Program space has no register or scratch region.
- R7: An internal request (register, scratch or internal RAM) has `ready_o` high in the cycle it is presented, and `ext_strobe_o` stays low.
- R8: When an external request is accepted, `ext_strobe_o` pulses high for that one cycle. `ready_o` is then low for exactly the wait count, in cycles, counted from the accepting cycle, and high in the following cycle.
- R9: An external request presented in the cycle right after an external access completes gets `ready_o` low and no strobe for that cycle. It is accepted, with its strobe, in the next cycle. An internal request in that cycle is served at once.
- R10: All four region selects are low while `req_i` is low. Exactly one is high while `req_i` is high.
- R11: Out of reset with no request, `ready_o` is high and `ext_strobe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, held until ready |
| prog_i | input | 1 | 1 = program space, 0 = data space |
| addr_i | input | 20 | Page in bits 19:16, offset in bits 15:0 |
| ovly_i | input | 1 | Overlay: map internal RAM into the low 16K of every program page |
| sel_mmr_o | output | 1 | Memory-mapped register select |
| sel_scr_o | output | 1 | Scratch RAM select |
| sel_int_o | output | 1 | Internal RAM select |
| sel_ext_o | output | 1 | External memory select |
| ready_o | output | 1 | Access completes in this cycle |
| ext_strobe_o | output | 1 | External access start pulse |

## Verification
The hardest case to reach is the recovery cycle. It needs an external request to arrive exactly one cycle after another external access has finished. An ordinary requester drops its request in between, so it never creates this case. The bench handles it in a directed test: on the completion cycle of a data access it keeps `req_i` high and switches to a new external address, then checks the held-off cycle and the delayed strobe. It repeats the same timing with an internal address to show that internal requests pass straight through.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int OFF_W = 16;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_MMR,
        RG_SCR,
        RG_INT,
        RG_EXT
    } region_e;

    localparam int NUM_SEL = 4;

    localparam logic [OFF_W-1:0] MMR_LAST = 16'h005F;
    localparam logic [OFF_W-1:0] SCR_LAST = 16'h007F;
    localparam logic [OFF_W-1:0] INT_LAST = 16'h3FFF;

    // Region of one access; the page number never matters.
    function automatic region_e decode_fn(input logic is_prog,
                                          input logic [OFF_W-1:0] off,
                                          input logic ovly);
        region_e r;
        if (is_prog) begin
            r = (ovly && off <= INT_LAST) ? RG_INT : RG_EXT;
        end else if (off <= MMR_LAST) begin
            r = RG_MMR;
        end else if (off <= SCR_LAST) begin
            r = RG_SCR;
        end else if (off <= INT_LAST) begin
            r = RG_INT;
        end else begin
            r = RG_EXT;
        end
        return r;
    endfunction

endpackage

// File: rtl/memmap_decode.sv
module memmap_decode
    import memmap_pkg::*;
#(
    parameter int WS_W    = 4,
    parameter int DATA_WS = 1,
    parameter int PROG_WS = 7
) (
    input  logic                   req,
    input  logic                   is_prog,
    input  logic [OFF_W-1:0]       off,
    input  logic                   ovly,
    output logic [NUM_SEL-1:0]     sel,
    output logic                   is_ext,
    output logic [WS_W-1:0]        ws
);

    region_e region;

    always_comb begin
        region = decode_fn(is_prog, off, ovly);
    end

    // sel[0]=registers, sel[1]=scratch, sel[2]=internal RAM, sel[3]=external
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel[i] = req && (region == region_e'(i + 1));
    end

    assign is_ext = (region == RG_EXT);
    assign ws     = is_prog ? WS_W'(PROG_WS) : WS_W'(DATA_WS);

endmodule

// File: rtl/memmap_extseq.sv
module memmap_extseq #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            is_ext,
    input  logic [WS_W-1:0] ws,
    output logic            ready,
    output logic            strobe,
    output logic            busy
);

    logic [WS_W-1:0] remain;
    logic            recov;
    logic            accept;
    logic            last_wait;
    logic            ext_done;

    always_comb begin
        accept    = req && is_ext && !busy && !recov;
        last_wait = busy && (remain == WS_W'(1));
        ext_done  = last_wait || (accept && ws == '0);
        strobe    = accept;
        if (busy) begin
            ready = last_wait;
        end else begin
            ready = !(req && is_ext) || (accept && ws == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            recov  <= 1'b0;
        end else begin
            recov <= ext_done;
            if (accept && ws != '0) begin
                busy   <= 1'b1;
                remain <= ws;
            end else if (busy) begin
                remain <= remain - WS_W'(1);
                if (last_wait) begin
                    busy <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/memmap_waitgen.sv
module memmap_waitgen
    import memmap_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int WS_W    = 4,
    parameter int DATA_WS = 1,
    parameter int PROG_WS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              prog_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ovly_i,
    output logic              sel_mmr_o,
    output logic              sel_scr_o,
    output logic              sel_int_o,
    output logic              sel_ext_o,
    output logic              ready_o,
    output logic              ext_strobe_o
);

    logic [NUM_SEL-1:0] sel;
    logic               is_ext;
    logic [WS_W-1:0]    ws;
    logic               seq_busy;
    logic               unused_page;

    assign unused_page = ^addr_i[ADDR_W-1:OFF_W];

    memmap_decode #(
        .WS_W   (WS_W),
        .DATA_WS(DATA_WS),
        .PROG_WS(PROG_WS)
    ) u_dec (
        .req    (req_i),
        .is_prog(prog_i),
        .off    (addr_i[OFF_W-1:0]),
        .ovly   (ovly_i),
        .sel    (sel),
        .is_ext (is_ext),
        .ws     (ws)
    );

    memmap_extseq #(
        .WS_W(WS_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (req_i),
        .is_ext(is_ext),
        .ws    (ws),
        .ready (ready_o),
        .strobe(ext_strobe_o),
        .busy  (seq_busy)
    );

    assign sel_mmr_o = sel[0];
    assign sel_scr_o = sel[1];
    assign sel_int_o = sel[2];
    assign sel_ext_o = sel[3];

endmodule

// File: rtl/memmap_waitgen_chk.sv
module memmap_waitgen_chk #(
    parameter int WS_W    = 4,
    parameter int DATA_WS = 1,
    parameter int PROG_WS = 7
) (
    input logic clk,
    input logic rst,
    input logic req_i,
    input logic prog_i,
    input logic sel_mmr_o,
    input logic sel_scr_o,
    input logic sel_int_o,
    input logic sel_ext_o,
    input logic ready_o,
    input logic ext_strobe_o,
    input logic seq_busy
);

    logic [WS_W:0] wcnt;

    // Counts ready-low cycles since the last strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (ext_strobe_o) begin
            wcnt <= ready_o ? '0 : (WS_W+1)'(1);
        end else if (!ready_o) begin
            wcnt <= wcnt + (WS_W+1)'(1);
        end
    end

    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        req_i |-> $onehot({sel_mmr_o, sel_scr_o, sel_int_o, sel_ext_o}));

    p_sel_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_i |-> ({sel_mmr_o, sel_scr_o, sel_int_o, sel_ext_o} == 4'b0000));

    p_int_zero_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (req_i && !seq_busy && !sel_ext_o) |-> (ready_o && !ext_strobe_o));

    p_strobe_ext_r8: assert property (@(posedge clk) disable iff (rst)
        ext_strobe_o |-> (req_i && sel_ext_o));

    p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
        ext_strobe_o |=> !ext_strobe_o);

    p_recovery_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i && sel_ext_o && ready_o) |=> !ext_strobe_o);

    p_wait_len_r8: assert property (@(posedge clk) disable iff (rst)
        (req_i && sel_ext_o && ready_o && !ext_strobe_o) |->
        (wcnt == (prog_i ? (WS_W+1)'(PROG_WS) : (WS_W+1)'(DATA_WS))));

endmodule

bind memmap_waitgen memmap_waitgen_chk #(
    .WS_W   (WS_W),
    .DATA_WS(DATA_WS),
    .PROG_WS(PROG_WS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .prog_i      (prog_i),
    .sel_mmr_o   (sel_mmr_o),
    .sel_scr_o   (sel_scr_o),
    .sel_int_o   (sel_int_o),
    .sel_ext_o   (sel_ext_o),
    .ready_o     (ready_o),
    .ext_strobe_o(ext_strobe_o),
    .seq_busy    (seq_busy)
);

// File: tb/tb_memmap_waitgen.sv
module tb_memmap_waitgen;

    localparam int DATA_WS = 1;
    localparam int PROG_WS = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic        prog_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic        ovly_i = 1'b0;
    logic        sel_mmr_o, sel_scr_o, sel_int_o, sel_ext_o, ready_o, ext_strobe_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    memmap_waitgen #(.DATA_WS(DATA_WS), .PROG_WS(PROG_WS)) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .prog_i(prog_i), .addr_i(addr_i),
        .ovly_i(ovly_i), .sel_mmr_o(sel_mmr_o), .sel_scr_o(sel_scr_o),
        .sel_int_o(sel_int_o), .sel_ext_o(sel_ext_o), .ready_o(ready_o),
        .ext_strobe_o(ext_strobe_o)
    );

    // sel code: {ext,int,scr,mmr}
    typedef struct packed {
        logic        prog;
        logic        ovly;
        logic [19:0] addr;
        logic [3:0]  sel;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 20'h00000, 4'b0001, 4'd1},  // R1 low edge
        '{1'b0, 1'b0, 20'h0005F, 4'b0001, 4'd1},  // R1 high edge
        '{1'b0, 1'b0, 20'hF0010, 4'b0001, 4'd1},  // R1 page bits ignored
        '{1'b0, 1'b0, 20'h00060, 4'b0010, 4'd2},  // R2
        '{1'b0, 1'b0, 20'h0007F, 4'b0010, 4'd2},  // R2
        '{1'b0, 1'b0, 20'h00080, 4'b0100, 4'd3},  // R3
        '{1'b0, 1'b1, 20'h03FFF, 4'b0100, 4'd3},  // R3
        '{1'b0, 1'b0, 20'h04000, 4'b1000, 4'd4},  // R4
        '{1'b0, 1'b0, 20'h0FFFF, 4'b1000, 4'd4},  // R4
        '{1'b1, 1'b0, 20'h00100, 4'b1000, 4'd5},  // R5
        '{1'b1, 1'b0, 20'hF3FFF, 4'b1000, 4'd5},  // R5
        '{1'b1, 1'b1, 20'h00000, 4'b0100, 4'd6},  // R6
        '{1'b1, 1'b1, 20'h53FFF, 4'b0100, 4'd6},  // R6
        '{1'b1, 1'b1, 20'h24000, 4'b1000, 4'd6},  // R6
        '{1'b1, 1'b1, 20'h00060, 4'b0100, 4'd6}   // R6 no register region
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [3:0] sels();
        return {sel_ext_o, sel_int_o, sel_scr_o, sel_mmr_o};
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic present(input logic p, input logic o, input logic [19:0] a);
        @(negedge clk);
        req_i = 1'b1; prog_i = p; ovly_i = o; addr_i = a;
        #1;
    endtask

    // Counts ready-low cycles starting at the current cycle.
    task automatic count_wait(output int n);
        n = 0;
        while (!ready_o && n < 40) begin
            n++;
            step();
        end
    endtask

    task automatic release_bus();
        @(negedge clk);
        req_i = 1'b0;
        step();
        step();
    endtask

    initial begin
        int n;
        repeat (3) step();
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R11", "ready after reset", ready_o, 1);
        chk("R11", "strobe after reset", ext_strobe_o, 0);
        chk("R10", "sel idle", sels(), 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].rq);
            present(VECS[i].prog, VECS[i].ovly, VECS[i].addr);
            chk(tag, $sformatf("sel vec %0d", i), sels(), VECS[i].sel);
            chk("R7", $sformatf("ready vec %0d", i), ready_o, !VECS[i].sel[3]);
            chk("R8", $sformatf("strobe vec %0d", i), ext_strobe_o, VECS[i].sel[3]);
            if (VECS[i].sel[3]) count_wait(n);
            release_bus();
        end

        // R4 / R8: data external wait length and single strobe
        present(1'b0, 1'b0, 20'h08000);
        step();
        chk("R8", "strobe one cycle", ext_strobe_o, 0);
        count_wait(n);
        chk("R4", "data wait count", n + 1, DATA_WS);
        release_bus();

        // R5 / R8: program flash wait length
        present(1'b1, 1'b0, 20'h31234);
        count_wait(n);
        chk("R5", "program wait count", n, PROG_WS);
        chk("R8", "ready at completion", ready_o, 1);
        release_bus();

        // R9: back-to-back external request
        present(1'b0, 1'b0, 20'h05000);
        count_wait(n);
        @(negedge clk); addr_i = 20'h06000; #1;
        chk("R9", "held-off ready", ready_o, 0);
        chk("R9", "held-off strobe", ext_strobe_o, 0);
        step();
        chk("R9", "delayed strobe", ext_strobe_o, 1);
        chk("R9", "delayed ready low", ready_o, 0);
        count_wait(n);
        chk("R9", "delayed wait count", n, DATA_WS);

        // R9: internal request in recovery cycle is served at once
        @(negedge clk); addr_i = 20'h01000; #1;
        chk("R9", "internal in recovery ready", ready_o, 1);
        chk("R9", "internal in recovery sel", sels(), 4'b0100);
        chk("R9", "internal in recovery strobe", ext_strobe_o, 0);
        release_bus();

        // R10: request low gives no select
        @(negedge clk); addr_i = 20'h04000; #1;
        chk("R10", "no sel without req", sels(), 0);
        chk("R11", "idle ready", ready_o, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule